// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a free-running reference clock into the timing pulses a UART needs. A divisor made of an integer part and a fraction in sixteenths sets the length of one tick period in reference cycles. When the fraction is nonzero, some periods are one reference cycle longer than the others. The longer periods are spread evenly, so the average period matches the programmed divisor, at the cost of cycle-to-cycle jitter.

A rate select sets how many ticks make up one bit time: sixteen in standard mode, eight in double-rate mode and four in quad-rate mode. The clock-out pin runs at the tick rate, so its ratio to the baud rate follows the selected mode. A bit strobe marks the end of each bit time.

No pulse leaves the block until the reference has been reported stable for a programmable number of cycles. The ready output then rises. All pins are plain control and status pins. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `frac_baud_gen`

## Requirements
- R1: `ready` rises on the (`settle_len`+1)-th consecutive rising edge at which `ref_stable` is sampled high.
- R2: A rising edge that samples `ref_stable` low clears `ready` at that edge. The settle count then restarts from zero.
- R3: While `ready` is low, `sample_tick`, `bit_tick` and `clk_out` are all low. This includes the time during and straight after reset.
- R4: With `div_frac` = 0 and a nonzero `div_int` of N, `sample_tick` pulses for one cycle every N cycles. The first pulse is in the N-th cycle in which `ready` is high.
- R5: A `div_int` of 0 acts as 1. With `div_frac` = 0, `sample_tick` is high in every cycle in which `ready` is high.
- R6: Number the tick periods from k = 0 at the rise of `ready`. With fraction f (0..15), period k lasts max(`div_int`,1)+1 cycles when floor((k+1)·f/16) > floor(k·f/16), and max(`div_int`,1) cycles otherwise. Each group of 16 periods therefore holds exactly f stretched periods, evenly placed.
- R7: `bit_tick` is high together with every R-th `sample_tick` counted from the rise of `ready`, and at no other time. R = 16 for `rate_sel` 0, 8 for `rate_sel` 1, and 4 for `rate_sel` 2 or 3.
- R8: Within a tick period of L cycles that ends with the `sample_tick` cycle, `clk_out` is high for the first floor(L/2) cycles and low for the rest. A one-cycle period therefore leaves `clk_out` low. `clk_out` runs at the tick rate, which is R times the baud rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stable | input | 1 | High while the reference clock source is settled |
| settle_len | input | SETTLE_W (12) | Reference cycles of stability required before ready |
| div_int | input | INT_W (16) | Integer part of the divisor (0 acts as 1) |
| div_frac | input | FRAC_W (4) | Fractional part of the divisor, in sixteenths |
| rate_sel | input | 2 | 0 standard (16 ticks/bit), 1 double (8), 2 or 3 quad (4) |
| sample_tick | output | 1 | One-cycle oversampling tick |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit time |
| clk_out | output | 1 | Square-ish clock at the tick rate |
| ready | output | 1 | Generator settled and running |

## Verification
The period-length properties only judge a tick period when `div_int` and `div_frac` were held unchanged through the whole period, including the tick that opened it. The divide-by-one property likewise requires a zero divisor in the previous cycle as well. `ref_stable` is taken to be synchronous to `clk`. The stimulus changes the divisor, fraction and rate only while `ref_stable` is low, and then holds them for the entire run. This means every period observed while `ready` is high falls inside the assumptions.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  typedef enum logic [1:0] {
    RATE_STD  = 2'd0,
    RATE_X2   = 2'd1,
    RATE_X4   = 2'd2,
    RATE_X4_B = 2'd3
  } rate_e;

  localparam int TPB_W = 5;

  // ticks that make up one bit time for each rate setting
  function automatic logic [TPB_W-1:0] ticks_per_bit(input rate_e r);
    case (r)
      RATE_STD: ticks_per_bit = 5'd16;
      RATE_X2:  ticks_per_bit = 5'd8;
      default:  ticks_per_bit = 5'd4;
    endcase
  endfunction

endpackage

// File: rtl/fbg_settle.sv
module fbg_settle #(
  parameter int SETTLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stable_i,
  input  logic [SETTLE_W-1:0] settle_len_i,
  output logic                ready_o
);

  logic [SETTLE_W-1:0] cnt_q;
  logic                rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !stable_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (cnt_q < settle_len_i) cnt_q <= cnt_q + 1'b1;
      rdy_q <= (cnt_q >= settle_len_i);
    end
  end

  assign ready_o = rdy_q;

endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              tick_o,
  output logic              clk_out_o
);

  localparam int LEN_W = INT_W + 1;

  logic [LEN_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] phase_q;
  logic [FRAC_W:0]   phase_sum;
  logic [LEN_W-1:0]  base_len;
  logic [LEN_W-1:0]  cur_len;
  logic              stretch;
  logic              period_end;

  always_comb begin
    base_len   = (div_int_i == '0) ? LEN_W'(1) : {1'b0, div_int_i};
    phase_sum  = {1'b0, phase_q} + {1'b0, div_frac_i};
    stretch    = phase_sum[FRAC_W];
    cur_len    = base_len + {{(LEN_W-1){1'b0}}, stretch};
    period_end = (cnt_q >= cur_len - LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (period_end) begin
      cnt_q   <= '0;
      phase_q <= phase_sum[FRAC_W-1:0];
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign tick_o    = run_i && period_end;
  assign clk_out_o = run_i && (cnt_q < (cur_len >> 1));

endmodule

// File: rtl/fbg_rate_scale.sv
module fbg_rate_scale
  import fbg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  logic  tick_i,
  input  rate_e rate_i,
  output logic  bit_tick_o
);

  logic [TPB_W-1:0] beat_q;
  logic [TPB_W-1:0] tpb;
  logic             last_beat;

  always_comb begin
    tpb       = ticks_per_bit(rate_i);
    last_beat = (beat_q >= tpb - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i)  beat_q <= '0;
    else if (tick_i)       beat_q <= last_beat ? '0 : beat_q + 1'b1;
  end

  assign bit_tick_o = tick_i && last_beat;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int INT_W    = 16,
  parameter int FRAC_W   = 4,
  parameter int SETTLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_stable,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic [INT_W-1:0]    div_int,
  input  logic [FRAC_W-1:0]   div_frac,
  input  logic [1:0]          rate_sel,
  output logic                sample_tick,
  output logic                bit_tick,
  output logic                clk_out,
  output logic                ready
);

  logic run;
  logic tick;

  fbg_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk          (clk),
    .rst_n        (rst_n),
    .stable_i     (ref_stable),
    .settle_len_i (settle_len),
    .ready_o      (run)
  );

  fbg_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .div_int_i  (div_int),
    .div_frac_i (div_frac),
    .tick_o     (tick),
    .clk_out_o  (clk_out)
  );

  fbg_rate_scale u_scale (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .tick_i     (tick),
    .rate_i     (rate_e'(rate_sel)),
    .bit_tick_o (bit_tick)
  );

  assign sample_tick = tick;
  assign ready       = run;

endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int INT_W    = 16,
  parameter int FRAC_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_stable,
  input logic [INT_W-1:0]  div_int,
  input logic [FRAC_W-1:0] div_frac,
  input logic              sample_tick,
  input logic              bit_tick,
  input logic              clk_out,
  input logic              ready
);

  localparam int GAP_W = INT_W + 2;

  logic [GAP_W-1:0]  gap_q;
  logic              seen_q;
  logic              cfg_ok_q;
  logic [INT_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  logic [GAP_W-1:0]  base_n;
  logic              cfg_same;

  always_comb begin
    base_n   = (div_int == '0) ? GAP_W'(1) : GAP_W'(div_int);
    cfg_same = (div_int == div_q) && (div_frac == frac_q);
  end

  always_ff @(posedge clk) begin
    div_q  <= div_int;
    frac_q <= div_frac;
    if (!rst_n || !ready) begin
      gap_q    <= '0;
      seen_q   <= 1'b0;
      cfg_ok_q <= 1'b0;
    end else if (sample_tick) begin
      gap_q    <= GAP_W'(1);
      seen_q   <= 1'b1;
      cfg_ok_q <= cfg_same;
    end else begin
      if (gap_q != '1) gap_q <= gap_q + 1'b1;
      cfg_ok_q <= cfg_ok_q && cfg_same;
    end
  end

  // R1: ready may only rise after a stable reference
  a_r1_ready_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(ref_stable));

  // R2: losing stability drops ready at the next edge
  a_r2_drop_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_stable |=> !ready);

  // R3: nothing leaves the block while not ready
  a_r3_quiet_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !sample_tick && !bit_tick);

  a_r3_quiet_clk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> ready);

  // R4: zero fraction gives an exact period
  a_r4_exact_period: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && seen_q && cfg_ok_q && cfg_same && div_frac == '0) |-> gap_q == base_n);

  // R5: zero divisor ticks every cycle
  a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && div_int == '0 && div_frac == '0 && $past(div_int) == '0 && $past(div_frac) == '0)
      |-> sample_tick);

  // R6: a fractional period is N or N+1 cycles long
  a_r6_period_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && seen_q && cfg_ok_q && cfg_same) |-> (gap_q == base_n || gap_q == base_n + 1'b1));

  // R7: the bit strobe always lands on a tick
  a_r7_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

endmodule

bind frac_baud_gen fbg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_stable  (ref_stable),
  .div_int     (div_int),
  .div_frac    (div_frac),
  .sample_tick (sample_tick),
  .bit_tick    (bit_tick),
  .clk_out     (clk_out),
  .ready       (ready)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_stable;
  logic [11:0] settle_len;
  logic [15:0] div_int;
  logic [3:0]  div_frac;
  logic [1:0]  rate_sel;
  logic        sample_tick, bit_tick, clk_out, ready;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ref_stable(ref_stable), .settle_len(settle_len),
    .div_int(div_int), .div_frac(div_frac), .rate_sel(rate_sel),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .clk_out(clk_out), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_stable = 1'b0; settle_len = 12'd5;
    div_int = 16'd2; div_frac = 4'd0; rate_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R3", "ready in reset", int'(ready), 0);
    chk(sample_tick == 1'b0 && bit_tick == 1'b0 && clk_out == 1'b0, "R3", "outputs in reset",
        int'({sample_tick, bit_tick, clk_out}), 0);
    rst_n = 1'b1;
  endtask

  // ref_stable driven high at the current negedge; expect ready at the (len+1)th negedge after
  task automatic expect_ready_after(input int len, input string req);
    for (int k = 1; k <= len + 1; k++) begin
      @(negedge clk);
      if (k == len) chk(ready == 1'b0, req, "ready one cycle early", int'(ready), 0);
      if (k <= len) chk(!sample_tick && !clk_out, "R3", "quiet while settling",
                        int'({sample_tick, clk_out}), 0);
      if (k == len + 1) chk(ready == 1'b1, req, "ready on time", int'(ready), 1);
    end
  endtask

  task automatic t_settle();
    @(negedge clk);
    settle_len = 12'd5; ref_stable = 1'b1;
    expect_ready_after(5, "R1");
  endtask

  task automatic t_drop();
    int ticks;
    @(negedge clk);
    ref_stable = 1'b0;
    @(negedge clk);
    div_int = 16'd0; settle_len = 12'd5; ref_stable = 1'b1;
    expect_ready_after(5, "R2");
    ticks = 0;
    repeat (4) begin
      @(negedge clk);
      if (sample_tick) ticks++;
    end
    chk(ticks == 4, "R5", "ticks before drop", ticks, 4);
    ref_stable = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R2", "ready after drop", int'(ready), 0);
    ticks = 0;
    repeat (6) begin
      if (sample_tick || bit_tick || clk_out) ticks++;
      @(negedge clk);
    end
    chk(ticks == 0, "R3", "activity after drop", ticks, 0);
  endtask

  task automatic run_cfg(input int dv, input int fr, input int rs, input int nticks,
                         input string req_tick);
    int n, r, p, k, len, e_tick, e_clk, e_bit, st;
    int err_t, err_c, err_b;
    @(negedge clk);
    ref_stable = 1'b0;
    @(negedge clk);
    div_int = 16'(dv); div_frac = 4'(fr); rate_sel = 2'(rs); settle_len = 12'd2;
    ref_stable = 1'b1;
    expect_ready_after(2, "R1");
    n = (dv == 0) ? 1 : dv;
    r = (rs == 0) ? 16 : (rs == 1) ? 8 : 4;
    p = 0; k = 0; err_t = 0; err_c = 0; err_b = 0;
    while (k < nticks) begin
      st     = (((k % 16) + 1) * fr / 16 != (k % 16) * fr / 16) ? 1 : 0;
      len    = n + st;
      e_tick = (p == len - 1) ? 1 : 0;
      e_clk  = (p < len / 2) ? 1 : 0;
      e_bit  = (e_tick == 1 && ((k + 1) % r) == 0) ? 1 : 0;
      if (int'(sample_tick) != e_tick) begin
        if (err_t == 0) $display("FAIL %s tick period %0d pos %0d actual=%0d expected=%0d",
                                 req_tick, k, p, sample_tick, e_tick);
        err_t++;
      end
      if (int'(clk_out) != e_clk) begin
        if (err_c == 0) $display("FAIL R8 clk_out period %0d pos %0d actual=%0d expected=%0d",
                                 k, p, clk_out, e_clk);
        err_c++;
      end
      if (int'(bit_tick) != e_bit) begin
        if (err_b == 0) $display("FAIL R7 bit_tick period %0d actual=%0d expected=%0d",
                                 k, bit_tick, e_bit);
        err_b++;
      end
      if (e_tick == 1) begin p = 0; k++; end
      else p++;
      @(negedge clk);
    end
    total += 3;
    if (err_t != 0) bad++;
    if (err_c != 0) bad++;
    if (err_b != 0) bad++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_settle();
    t_drop();
    run_cfg(5, 0, 0, 48, "R4");   // exact period, standard rate
    run_cfg(0, 0, 2, 40, "R5");   // divide-by-one, quad rate
    run_cfg(3, 8, 1, 48, "R6");   // every other period stretched
    run_cfg(4, 3, 3, 48, "R6");   // sparse stretching, rate code 3
    run_cfg(1, 15, 0, 64, "R6");  // nearly all stretched, 1-cycle periods keep clk_out low
    run_cfg(7, 5, 1, 40, "R6");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule